// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Retry Controller

This block sits beside the transmit datapath of a half-duplex Ethernet MAC and decides, frame by frame, when the datapath may send. A frame-start request moves the block into a carrier wait. When the medium is quiet it raises a go signal. While go is high, the datapath reports each byte it sends, the end of the frame, and any collision.

Collisions are sorted by how many bytes have gone out when they occur. Early collisions lead to a new attempt, normally after a randomised back-off of whole slot times. Late collisions, or too many collisions, end the frame with an abort. Two configuration bits shorten the path back to transmission: one skips the back-off always, the other skips it only while back-pressure is applied. A third bit lets the block wait for carrier with no time limit.

When a frame ends, the block gives a one-cycle completion pulse. A 16-bit status word holds the collision count, the error flags and an ownership flag.

Top module: `txcoll_ctrl`

## Requirements
- R1: While reset is held and directly after it, `go_o` and `done_o` are 0 and `status_o` is 0x0000.
- R2: A `start_i` pulse in the idle state sets status bit 15 (owner, 1 = MAC holds the frame) and clears the other status bits. With `crs_i` low, `go_o` is low for exactly one sampled cycle and then rises. Status bit 15 is 1 whenever `go_o` is 1.
- R3: While `crs_i` is high outside transmission, `go_o` stays low. A frame that waits on carrier gets status bit 8 (deferred) set.
- R4: A collision while fewer than `cfg_late_thr_i` bytes have been strobed in the current attempt is retried. `go_o` falls on the next cycle, and status bits 3:0 count every collision of the frame, saturating at 15.
- R5: A collision when the byte count of the attempt is at or above `cfg_late_thr_i` ends the frame. It sets bit 5 (late) and bit 14 (abort). This check takes priority over the retry limit.
- R6: When the collision count exceeds `cfg_retry_max_i`, the frame ends with bit 4 (max collisions) and bit 14 set.
- R7: After early collision number n, with neither skip mode active, `go_o` stays low for 512·S + 2 cycles when `tick_i` is held high. S is a random slot count in 0 .. 2^min(n,10) − 1.
- R8: With `cfg_skip_bo_i` set, `go_o` stays low for exactly one cycle after an early collision.
- R9: With `cfg_bp_skip_i` set and `bp_i` high at the collision, the gap is one cycle. `bp_i` high at any cycle of an active frame sets status bit 13.
- R10: With `cfg_defer_forever_i` clear, the 24,288th bit tick of continuous carrier in one wait ends the frame with bits 7 (excess deferral), 8 and 14 set. This is sampled as `done_o` 24,289 cycles after the start edge.
- R11: With `cfg_defer_forever_i` set, carrier of any length never ends the frame. Transmission starts once carrier drops, and bit 7 stays clear.
- R12: Completion, after `done_i` or an abort, gives `done_o` for exactly one cycle. Status bit 15 is cleared at that point, and a normal finish carries only the count and the deferred and back-pressure bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame-start request, taken in idle |
| byte_i | input | 1 | One byte sent by the datapath this cycle |
| done_i | input | 1 | Datapath finished the frame |
| coll_i | input | 1 | Collision detected |
| crs_i | input | 1 | Carrier sense |
| tick_i | input | 1 | One bit time elapsed |
| bp_i | input | 1 | Back-pressure currently applied |
| cfg_late_thr_i | input | 6 | Byte count separating early from late collisions |
| cfg_retry_max_i | input | 4 | Retransmissions allowed |
| cfg_skip_bo_i | input | 1 | Retry with no back-off |
| cfg_bp_skip_i | input | 1 | Retry with no back-off while back-pressure is on |
| cfg_defer_forever_i | input | 1 | Wait on carrier without a limit |
| go_o | output | 1 | Datapath may transmit |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 16 | Completion status word |

## Verification
The bench puts collisions exactly one byte below and exactly at the late threshold. A comparator off by one would retry a late collision or abort an early one, and the status word would show it. It drives the retry limit at 0 and at 15 with 15 and 16 collisions. A wrong limit compare or an unsaturated count field would end the frame one collision early or late, or wrap the count to 0. It measures every back-off gap and accepts only exact multiples of the slot plus two cycles within the allowed window, and exactly one cycle in the skip modes. A design that ignores a skip bit, or does not truncate the exponent, is caught there. A long carrier hold checks the exact cycle of the excess-deferral abort, and its absence when the wait is unlimited.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DEFER   = 2'd1,
        ST_XMIT    = 2'd2,
        ST_BACKOFF = 2'd3
    } txc_state_e;

    // status word bit positions, decoded by the descriptor writer
    localparam int SB_MAXCOL = 4;
    localparam int SB_LATE   = 5;
    localparam int SB_XSDEF  = 7;
    localparam int SB_DEFER  = 8;
    localparam int SB_BP     = 13;
    localparam int SB_ABORT  = 14;
    localparam int SB_OWN    = 15;
endpackage

// File: rtl/txc_lfsr.sv
module txc_lfsr #(
    parameter int           W    = 10,
    parameter logic [W-1:0] TAPS = 10'h240,
    parameter logic [W-1:0] SEED = 10'h15B
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd_o
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = {state_q[W-2:0], ^(state_q & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign rnd_o = state_q;

    // a zero state would freeze the back-off at zero slots forever
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/txc_slot_timer.sv
module txc_slot_timer #(
    parameter int SLOT_BITS = 512,
    parameter int SLOT_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SLOT_W-1:0] slots_i,
    input  logic              tick_i,
    output logic              busy_o
);
    localparam int TW = $clog2(SLOT_BITS);

    typedef struct packed {
        logic [SLOT_W-1:0] slots;
        logic [TW-1:0]     tcnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.slots = slots_i;
            d.tcnt  = '0;
        end else if (tick_i && q.slots != '0) begin
            if (q.tcnt == TW'(SLOT_BITS - 1)) begin
                d.tcnt  = '0;
                d.slots = q.slots - 1'b1;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.slots != '0);

    assert_slot_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !load_i |=> q.slots <= $past(q.slots));
endmodule

// File: rtl/txcoll_ctrl.sv
module txcoll_ctrl
    import txc_pkg::*;
#(
    parameter int LATE_W      = 6,
    parameter int RETRY_W     = 4,
    parameter int BO_CAP      = 10,
    parameter int SLOT_BITS   = 512,
    parameter int XSDEF_LIMIT = 24287,
    parameter logic [BO_CAP-1:0] LFSR_TAPS = 10'h240,
    parameter logic [BO_CAP-1:0] LFSR_SEED = 10'h15B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_i,
    input  logic              done_i,
    input  logic              coll_i,
    input  logic              crs_i,
    input  logic              tick_i,
    input  logic              bp_i,
    input  logic [LATE_W-1:0] cfg_late_thr_i,
    input  logic [RETRY_W-1:0] cfg_retry_max_i,
    input  logic              cfg_skip_bo_i,
    input  logic              cfg_bp_skip_i,
    input  logic              cfg_defer_forever_i,
    output logic              go_o,
    output logic              done_o,
    output logic [15:0]       status_o
);
    localparam int CNT_W = RETRY_W + 1;
    localparam int DEF_W = $clog2(XSDEF_LIMIT + 2);

    typedef struct packed {
        txc_state_e        st;
        logic [LATE_W-1:0] nbyte;
        logic [CNT_W-1:0]  ncoll;
        logic [DEF_W-1:0]  dcnt;
        logic [15:0]       stat;
        logic              done;
    } ctl_t;

    ctl_t d, q;

    logic              bo_load, bo_busy, fin;
    logic [CNT_W-1:0]  n1;
    logic [BO_CAP-1:0] bo_mask, rnd;
    int                kexp;

    txc_lfsr #(.W(BO_CAP), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    txc_slot_timer #(.SLOT_BITS(SLOT_BITS), .SLOT_W(BO_CAP)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (bo_load),
        .slots_i (rnd & bo_mask),
        .tick_i  (tick_i),
        .busy_o  (bo_busy)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        bo_load = 1'b0;
        fin     = 1'b0;
        n1      = q.ncoll + 1'b1;
        // truncated exponent for the back-off window
        kexp    = (int'(n1) > BO_CAP) ? BO_CAP : int'(n1);
        for (int i = 0; i < BO_CAP; i++) bo_mask[i] = (i < kexp);

        if (q.st != ST_IDLE && bp_i) d.stat[SB_BP] = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_DEFER;
                    d.nbyte = '0;
                    d.ncoll = '0;
                    d.dcnt  = '0;
                    d.stat  = '0;
                    d.stat[SB_OWN] = 1'b1;
                end
            end
            ST_DEFER: begin
                if (crs_i) begin
                    d.stat[SB_DEFER] = 1'b1;
                    if (tick_i) begin
                        if (q.dcnt == DEF_W'(XSDEF_LIMIT)) begin
                            if (!cfg_defer_forever_i) begin
                                fin = 1'b1;
                                d.stat[SB_XSDEF] = 1'b1;
                                d.stat[SB_ABORT] = 1'b1;
                            end
                        end else begin
                            d.dcnt = q.dcnt + 1'b1;
                        end
                    end
                end else begin
                    d.st    = ST_XMIT;
                    d.nbyte = '0;
                    d.dcnt  = '0;
                end
            end
            ST_XMIT: begin
                if (coll_i) begin
                    d.ncoll = n1;
                    d.stat[RETRY_W-1:0] = n1[CNT_W-1] ? '1 : n1[RETRY_W-1:0];
                    if (q.nbyte >= cfg_late_thr_i) begin
                        fin = 1'b1;
                        d.stat[SB_LATE]  = 1'b1;
                        d.stat[SB_ABORT] = 1'b1;
                    end else if (n1 > {1'b0, cfg_retry_max_i}) begin
                        fin = 1'b1;
                        d.stat[SB_MAXCOL] = 1'b1;
                        d.stat[SB_ABORT]  = 1'b1;
                    end else if (cfg_skip_bo_i || (cfg_bp_skip_i && bp_i)) begin
                        d.st = ST_DEFER;
                    end else begin
                        bo_load = 1'b1;
                        d.st    = ST_BACKOFF;
                    end
                end else if (done_i) begin
                    fin = 1'b1;
                end else if (byte_i && q.nbyte != '1) begin
                    d.nbyte = q.nbyte + 1'b1;
                end
            end
            ST_BACKOFF: begin
                if (!bo_busy) d.st = ST_DEFER;
            end
            default: d.st = ST_IDLE;
        endcase

        if (fin) begin
            d.st   = ST_IDLE;
            d.done = 1'b1;
            d.stat[SB_OWN] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign go_o     = (q.st == ST_XMIT);
    assign done_o   = q.done;
    assign status_o = q.stat;

    assert_owner_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> status_o[SB_OWN]);
    assert_carrier_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !go_o && crs_i |=> !go_o);
    assert_go_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go_o && coll_i |=> !go_o);
    assert_late_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && status_o[SB_LATE] |-> status_o[SB_ABORT]);
    assert_max_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && status_o[SB_MAXCOL] |-> status_o[SB_ABORT]);
    assert_owner_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !status_o[SB_OWN]);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/test_txcoll_ctrl.sv
module test_txcoll_ctrl;
    localparam int SLOT = 512;
    localparam int XSL  = 24287;

    logic clk = 1'b0;
    logic rst_n, start_i, byte_i, done_i, coll_i, crs_i, tick_i, bp_i;
    logic [5:0] cfg_late_thr_i;
    logic [3:0] cfg_retry_max_i;
    logic cfg_skip_bo_i, cfg_bp_skip_i, cfg_defer_forever_i;
    logic go_o, done_o;
    logic [15:0] status_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    txcoll_ctrl i_txcoll_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_i(byte_i),
        .done_i(done_i), .coll_i(coll_i), .crs_i(crs_i), .tick_i(tick_i),
        .bp_i(bp_i), .cfg_late_thr_i(cfg_late_thr_i),
        .cfg_retry_max_i(cfg_retry_max_i), .cfg_skip_bo_i(cfg_skip_bo_i),
        .cfg_bp_skip_i(cfg_bp_skip_i), .cfg_defer_forever_i(cfg_defer_forever_i),
        .go_o(go_o), .done_o(done_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_stat(int n, bit mx, bit lt, bit xd,
                                            bit df, bit bp, bit ab);
        logic [15:0] s = '0;
        s[3:0] = (n > 15) ? 4'd15 : 4'(n);
        s[4] = mx; s[5] = lt; s[7] = xd; s[8] = df; s[13] = bp; s[14] = ab;
        return s;
    endfunction

    task automatic check_gap(input int gap, input int n, input bit bp);
        int k, maxs;
        if (cfg_skip_bo_i) chk(gap == 1, "R8 skip gap", gap, 1);
        else if (cfg_bp_skip_i && bp) chk(gap == 1, "R9 bp gap", gap, 1);
        else begin
            k = (n > 10) ? 10 : n;
            maxs = (1 << k) - 1;
            chk(gap >= 2 && (gap - 2) % SLOT == 0 && (gap - 2) / SLOT <= maxs,
                "R7 back-off gap", gap, maxs * SLOT + 2);
        end
    endtask

    task automatic run_frame(input int c, input int pos, input int nbytes,
                             input bit bp, output logic [15:0] st);
        int att = 0;
        int gap = 0;
        bp_i = bp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            if (done_o) begin st = status_o; break; end
            if (!go_o) begin gap++; @(negedge clk); continue; end
            if (att == 0) chk(gap == 1 && status_o[15], "R2 first go",
                              {gap[15:0], status_o}, {16'd1, 16'h8000});
            else check_gap(gap, att, bp);
            gap = 0;
            if (att < c) begin
                for (int k = 0; k < pos; k++) begin byte_i = 1'b1; @(negedge clk); end
                byte_i = 1'b0; coll_i = 1'b1;
                @(negedge clk);
                coll_i = 1'b0;
                chk(!go_o, "R4 go drops", go_o, 0);
                att++;
            end else begin
                for (int k = 0; k < nbytes; k++) begin byte_i = 1'b1; @(negedge clk); end
                byte_i = 1'b0; done_i = 1'b1;
                @(negedge clk);
                done_i = 1'b0;
            end
        end
        @(negedge clk);
        chk(!done_o, "R12 done one cycle", done_o, 0);
        bp_i = 1'b0;
    endtask

    task automatic set_cfg(int late, int retry, bit skip, bit bpskip, bit forever_w);
        cfg_late_thr_i = 6'(late); cfg_retry_max_i = 4'(retry);
        cfg_skip_bo_i = skip; cfg_bp_skip_i = bpskip; cfg_defer_forever_i = forever_w;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] st;
        int cnt;
        void'($urandom(32'd4242));
        rst_n = 1'b0; start_i = 0; byte_i = 0; done_i = 0; coll_i = 0;
        crs_i = 0; tick_i = 1'b1; bp_i = 0;
        set_cfg(20, 4, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk(!go_o && !done_o && status_o == 0, "R1 in reset", {go_o, done_o, status_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!go_o && !done_o && status_o == 0, "R1 after reset", {go_o, done_o, status_o}, 0);

        // R2 R12 plain frame
        run_frame(0, 0, 10, 0, st);
        chk(st == 16'h0000, "R12 clean status", st, 16'h0000);

        // R4 R7 early collisions with back-off
        run_frame(3, 5, 6, 0, st);
        chk(st == mk_stat(3, 0, 0, 0, 0, 0, 0), "R4 count", st, mk_stat(3, 0, 0, 0, 0, 0, 0));

        // R5 boundary: one below and at threshold
        set_cfg(8, 4, 1, 0, 0);
        run_frame(1, 7, 3, 0, st);
        chk(st == mk_stat(1, 0, 0, 0, 0, 0, 0), "R4 below threshold", st, mk_stat(1, 0, 0, 0, 0, 0, 0));
        run_frame(1, 8, 3, 0, st);
        chk(st == mk_stat(1, 0, 1, 0, 0, 0, 1), "R5 at threshold", st, mk_stat(1, 0, 1, 0, 0, 0, 1));
        set_cfg(0, 4, 1, 0, 0);
        run_frame(1, 0, 3, 0, st);
        chk(st == mk_stat(1, 0, 1, 0, 0, 0, 1), "R5 zero threshold", st, mk_stat(1, 0, 1, 0, 0, 0, 1));

        // R6 retry limit, R8 skip mode
        set_cfg(40, 2, 1, 0, 0);
        run_frame(3, 2, 3, 0, st);
        chk(st == mk_stat(3, 1, 0, 0, 0, 0, 1), "R6 limit 2", st, mk_stat(3, 1, 0, 0, 0, 0, 1));
        set_cfg(40, 0, 1, 0, 0);
        run_frame(1, 2, 3, 0, st);
        chk(st == mk_stat(1, 1, 0, 0, 0, 0, 1), "R6 limit 0", st, mk_stat(1, 1, 0, 0, 0, 0, 1));
        set_cfg(40, 15, 1, 0, 0);
        run_frame(15, 1, 3, 0, st);
        chk(st == mk_stat(15, 0, 0, 0, 0, 0, 0), "R6 15 of 15", st, mk_stat(15, 0, 0, 0, 0, 0, 0));
        run_frame(16, 1, 3, 0, st);
        chk(st == mk_stat(16, 1, 0, 0, 0, 0, 1), "R6 16 saturates", st, mk_stat(16, 1, 0, 0, 0, 0, 1));

        // R9 back-pressure
        set_cfg(40, 4, 0, 1, 0);
        run_frame(2, 3, 3, 1, st);
        chk(st == mk_stat(2, 0, 0, 0, 0, 1, 0), "R9 bp skip", st, mk_stat(2, 0, 0, 0, 0, 1, 0));
        run_frame(1, 3, 3, 0, st);
        chk(st == mk_stat(1, 0, 0, 0, 0, 0, 0), "R9 bp off", st, mk_stat(1, 0, 0, 0, 0, 0, 0));
        set_cfg(40, 4, 0, 0, 0);
        run_frame(1, 3, 3, 1, st);
        chk(st == mk_stat(1, 0, 0, 0, 0, 1, 0), "R9 bp flag only", st, mk_stat(1, 0, 0, 0, 0, 1, 0));

        // R3 short deferral
        crs_i = 1'b1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            if (go_o) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R3 no go under carrier", cnt, 0);
        crs_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(go_o == 1'b1, "R3 go after carrier", go_o, 1);
        done_i = 1'b1; @(negedge clk); done_i = 1'b0;
        chk(done_o && status_o == mk_stat(0, 0, 0, 0, 1, 0, 0), "R3 deferred flag",
            status_o, mk_stat(0, 0, 0, 0, 1, 0, 0));
        @(negedge clk);

        // R10 excess deferral, exact cycle
        crs_i = 1'b1; start_i = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk); start_i = 1'b0; cnt++;
        end while (!done_o && cnt < 30000);
        chk(cnt == XSL + 2, "R10 abort cycle", cnt, XSL + 2);
        chk(status_o == mk_stat(0, 0, 0, 1, 1, 0, 1), "R10 status", status_o, mk_stat(0, 0, 0, 1, 1, 0, 1));
        @(negedge clk);

        // R11 unlimited wait
        cfg_defer_forever_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        cnt = 0;
        for (int i = 0; i < 26000; i++) begin
            if (go_o || done_o) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R11 still waiting", cnt, 0);
        crs_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(go_o == 1'b1, "R11 go after release", go_o, 1);
        done_i = 1'b1; @(negedge clk); done_i = 1'b0;
        chk(done_o && status_o == mk_stat(0, 0, 0, 0, 1, 0, 0), "R11 status",
            status_o, mk_stat(0, 0, 0, 0, 1, 0, 0));
        @(negedge clk);

        // random frames
        for (int f = 0; f < 20; f++) begin
            int late, retry, c, pos, nb;
            bit bp, lt;
            logic [15:0] ex;
            late  = 1 + int'($urandom % 63);
            retry = int'($urandom % 6);
            c     = int'($urandom % 4);
            lt    = ($urandom % 4) == 0;
            pos   = lt ? late : int'($urandom % late);
            nb    = 1 + int'($urandom % 20);
            bp    = $urandom % 2;
            set_cfg(late, retry, $urandom % 2, $urandom % 2, 0);
            run_frame(c, pos, nb, bp, st);
            if (c == 0) ex = mk_stat(0, 0, 0, 0, 0, bp, 0);
            else if (lt) ex = mk_stat(1, 0, 1, 0, 0, bp, 1);
            else if (c > retry) ex = mk_stat(retry + 1, 1, 0, 0, 0, bp, 1);
            else ex = mk_stat(c, 0, 0, 0, 0, bp, 0);
            chk(st == ex, "R4 R5 R6 R9 random frame", st, ex);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule